// File: doc/BRIEF.md
# Synchronous Burst Access Sequencer

This block sequences synchronous burst reads and writes on a 16-bit pseudo-static RAM interface. When chip select is active and the address strobe is low at a rising clock edge, it captures a 23-bit start address, the read/write direction, a latency code and a length code. It then counts out a programmable first-access latency and steps through data beats in linear order. For each beat it presents the word address, a beat strobe, the direction flag and the byte-lane enables.

While the latency runs, a wait flag tells the host that data is not yet valid. A separate enable output marks when that flag would be driven, so the surrounding pad logic can float it while the device is deselected. Fixed bursts of 8 or 16 words wrap inside their aligned block. A continuous burst walks the whole address space until chip select is released. Releasing chip select ends any activity at once.

Top module: `burst_seq`

## Requirements
- R1: In the cycle after a reset edge, beat_valid, wait_o, wait_oe and lane_en are all 0.
- R2: A rising edge with ce_n=0 and adv_n=0 captures addr_in. The first beat that follows shows exactly that address on beat_addr.
- R3: lat_code values 0 to 5 select a latency L of 5 to 10 clocks, and the values 6 and 7 select 10. beat_valid first rises in the cycle that follows the L-th rising edge after the capture edge.
- R4: wait_o is 1 in every cycle from the one after the capture edge up to the cycle before the first beat. It is 0 during beats and while idle.
- R5: wait_oe shows the inverse of ce_n as it was sampled at the previous rising edge.
- R6: len_code 0 gives exactly 8 beats. Only the low 3 address bits advance, by +1 modulo 8, and the upper bits hold.
- R7: len_code 1 gives exactly 16 beats. Only the low 4 address bits advance, by +1 modulo 16, and the upper bits hold.
- R8: len_code 2 or 3 gives a continuous burst. The address advances by +1 over the full 23 bits and wraps from 7FFFFF to 000000.
- R9: A rising edge with ce_n=1 ends any burst or latency count. In the next cycle beat_valid and wait_o are 0.
- R10: On each beat, lane_en[0] equals ~lb_n and lane_en[1] equals ~ub_n, both sampled at the edge that produced the beat. lane_en is 0 when no beat is valid.
- R11: beat_wr equals ~we_n as sampled at the capture edge, and it holds for the whole burst.
- R12: After a fixed burst ends, the block stays idle until a new capture. adv_n low while ce_n is high is ignored. A capture during a burst, including in the last beat's cycle, restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write select, active low (sampled at capture) |
| lb_n | input | 1 | Low byte select, active low |
| ub_n | input | 1 | High byte select, active low |
| addr_in | input | 23 | Start word address |
| lat_code | input | 3 | Latency code (latency = 5 + code, maximum 10) |
| len_code | input | 2 | Burst length code: 0 = 8, 1 = 16, 2/3 = continuous |
| beat_addr | output | 23 | Word address of the current beat |
| beat_valid | output | 1 | A data beat is active this cycle |
| beat_wr | output | 1 | Current burst is a write |
| lane_en | output | 2 | Byte lane enables {high, low} for the beat |
| wait_o | output | 1 | Data not yet valid |
| wait_oe | output | 1 | Drive enable for wait_o (0 means high impedance) |

## Verification
The sharpest collision comes when a new address strobe lands in the cycle that shows the final beat of a fixed burst. At that edge the sequencer must choose between falling idle and starting a fresh latency count. The bench provokes this by raising the strobe in the last beat's cycle with a new address, length and direction. It requires all 8 old beats to appear, then wait_o high in the very next cycle, then the new burst's beats after the new latency. A second overlap, chip-select release at the edge after the last observed beat of a continuous burst, is judged by requiring that no further beat appears and that both wait outputs drop together.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LAT   = 2'd1,
    ST_BURST = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    BL_SHORT = 2'd0,
    BL_LONG  = 2'd1,
    BL_CONT  = 2'd2
  } blen_t;

  function automatic blen_t decode_len(input logic [1:0] code);
    case (code)
      2'd0:    decode_len = BL_SHORT;
      2'd1:    decode_len = BL_LONG;
      default: decode_len = BL_CONT;
    endcase
  endfunction

endpackage

// File: rtl/burst_lat_cnt.sv
// Counts initial latency clocks; done is high once the target is reached.
module burst_lat_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tgt_q <= '1;
    end else if (load) begin
      cnt_q <= CW'(1);
      tgt_q <= load_val;
    end else if (tick) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign done = (cnt_q == tgt_q);
endmodule

// File: rtl/burst_addr_step.sv
// Next beat address: wrap within the aligned block for fixed lengths, full increment otherwise.
module burst_addr_step
  import burst_pkg::*;
#(
  parameter int AW       = 23,
  parameter int LEN_SHRT = 8,
  parameter int LEN_LONG = 16
) (
  input  logic [AW-1:0] cur,
  input  blen_t         mode,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] MASK_S = AW'(LEN_SHRT - 1);
  localparam logic [AW-1:0] MASK_L = AW'(LEN_LONG - 1);

  logic [AW-1:0] inc;
  logic [AW-1:0] mask;

  assign inc = cur + AW'(1);

  always_comb begin
    case (mode)
      BL_SHORT: mask = MASK_S;
      BL_LONG:  mask = MASK_L;
      default:  mask = '1;
    endcase
    nxt = (cur & ~mask) | (inc & mask);
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int AW       = 23,
  parameter int LAT_MIN  = 5,
  parameter int LAT_MAX  = 10,
  parameter int LEN_SHRT = 8,
  parameter int LEN_LONG = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic [AW-1:0] addr_in,
  input  logic [2:0]    lat_code,
  input  logic [1:0]    len_code,
  output logic [AW-1:0] beat_addr,
  output logic          beat_valid,
  output logic          beat_wr,
  output logic [1:0]    lane_en,
  output logic          wait_o,
  output logic          wait_oe
);
  localparam int CW       = $clog2(LAT_MAX + 1);
  localparam int BCW      = $clog2(LEN_LONG);
  localparam int LAT_SPAN = LAT_MAX - LAT_MIN;

  seq_state_t    state_q;
  blen_t         len_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nxt;
  logic [BCW-1:0] beat_cnt_q;
  logic          wr_q;
  logic          capture;
  logic          lat_done;
  logic          lat_tick;
  logic          last_beat;
  logic [CW-1:0] lat_target;

  assign capture = !ce_n && !adv_n;
  assign lat_tick = (state_q == ST_LAT) && !ce_n && adv_n && !lat_done;

  always_comb begin
    if (int'(lat_code) > LAT_SPAN) lat_target = CW'(LAT_MAX);
    else                           lat_target = CW'(LAT_MIN + int'(lat_code));
  end

  always_comb begin
    case (len_q)
      BL_SHORT: last_beat = (beat_cnt_q == BCW'(LEN_SHRT - 1));
      BL_LONG:  last_beat = (beat_cnt_q == BCW'(LEN_LONG - 1));
      default:  last_beat = 1'b0;
    endcase
  end

  burst_lat_cnt #(.CW(CW)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .load     (capture),
    .load_val (lat_target),
    .tick     (lat_tick),
    .done     (lat_done)
  );

  burst_addr_step #(.AW(AW), .LEN_SHRT(LEN_SHRT), .LEN_LONG(LEN_LONG)) u_step (
    .cur  (addr_q),
    .mode (len_q),
    .nxt  (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      len_q      <= BL_SHORT;
      addr_q     <= '0;
      beat_cnt_q <= '0;
      wr_q       <= 1'b0;
      beat_valid <= 1'b0;
      wait_o     <= 1'b0;
      lane_en    <= 2'b00;
    end else if (ce_n) begin
      state_q    <= ST_IDLE;
      beat_valid <= 1'b0;
      wait_o     <= 1'b0;
      lane_en    <= 2'b00;
    end else if (!adv_n) begin
      state_q    <= ST_LAT;
      len_q      <= decode_len(len_code);
      addr_q     <= addr_in;
      wr_q       <= !we_n;
      beat_valid <= 1'b0;
      wait_o     <= 1'b1;
      lane_en    <= 2'b00;
    end else begin
      case (state_q)
        ST_LAT: begin
          if (lat_done) begin
            state_q    <= ST_BURST;
            beat_cnt_q <= '0;
            beat_valid <= 1'b1;
            wait_o     <= 1'b0;
            lane_en    <= {!ub_n, !lb_n};
          end
        end
        ST_BURST: begin
          if (last_beat) begin
            state_q    <= ST_IDLE;
            beat_valid <= 1'b0;
            lane_en    <= 2'b00;
          end else begin
            addr_q     <= addr_nxt;
            beat_cnt_q <= beat_cnt_q + BCW'(1);
            lane_en    <= {!ub_n, !lb_n};
          end
        end
        default: begin
          beat_valid <= 1'b0;
          wait_o     <= 1'b0;
          lane_en    <= 2'b00;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wait_oe <= 1'b0;
    else     wait_oe <= !ce_n;
  end

  assign beat_addr = addr_q;
  assign beat_wr   = wr_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW       = 23,
  parameter int LEN_SHRT = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          adv_n,
  input logic [AW-1:0] beat_addr,
  input logic          beat_valid,
  input logic [1:0]    lane_en,
  input logic          wait_o,
  input logic          wait_oe
);
  localparam int LW = $clog2(LEN_SHRT);

  // R4: wait and a data beat never overlap
  assert_wait_vs_beat_R4: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> !wait_o);

  // R10: lanes are quiet when no beat is active
  assert_lanes_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !beat_valid |-> (lane_en == 2'b00));

  // R9: releasing chip select stops everything on the next cycle
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!beat_valid && !wait_o));

  // R2: a capture edge starts the latency window
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !adv_n) |=> (wait_o && !beat_valid));

  // R5: wait drive enable follows chip select
  assert_wait_oe_on_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ce_n) |=> wait_oe);
  assert_wait_oe_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && ce_n) |=> !wait_oe);

  // R6: consecutive beats step the low address bits by one
  assert_low_step_R6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid)) |->
      (beat_addr[LW-1:0] == LW'($past(beat_addr[LW-1:0]) + 1'b1)));
endmodule

bind burst_seq burst_seq_chk #(.AW(AW), .LEN_SHRT(LEN_SHRT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce_n       (ce_n),
  .adv_n      (adv_n),
  .beat_addr  (beat_addr),
  .beat_valid (beat_valid),
  .lane_en    (lane_en),
  .wait_o     (wait_o),
  .wait_oe    (wait_oe)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1;
  logic        adv_n = 1'b1;
  logic        we_n = 1'b1;
  logic        lb_n = 1'b1;
  logic        ub_n = 1'b1;
  logic [22:0] addr_in = '0;
  logic [2:0]  lat_code = '0;
  logic [1:0]  len_code = '0;
  logic [22:0] beat_addr;
  logic        beat_valid;
  logic        beat_wr;
  logic [1:0]  lane_en;
  logic        wait_o;
  logic        wait_oe;

  always #4 clk = ~clk;

  burst_seq uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr_in(addr_in), .lat_code(lat_code),
    .len_code(len_code), .beat_addr(beat_addr), .beat_valid(beat_valid),
    .beat_wr(beat_wr), .lane_en(lane_en), .wait_o(wait_o), .wait_oe(wait_oe)
  );

  typedef struct packed {
    logic [22:0] a;
    logic        wr;
    logic [1:0]  ln;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: every beat must match the next expected item.
  always @(negedge clk) begin
    if (!rst && beat_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12", "unexpected beat", int'(beat_addr), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(beat_addr == e.a, "R2/R6/R7/R8", "beat address", int'(beat_addr), int'(e.a));
        chk(beat_wr == e.wr, "R11", "write flag", int'(beat_wr), int'(e.wr));
        chk(lane_en == e.ln, "R10", "lane enables", int'(lane_en), int'(e.ln));
      end
    end
  end

  function automatic int lat_of(input int lc);
    return (lc > 5) ? 10 : 5 + lc;
  endfunction

  task automatic present(input logic [22:0] a, input int lc, input int bc,
                         input logic we, input logic lb, input logic ub);
    ce_n = 1'b0; adv_n = 1'b0; addr_in = a;
    lat_code = 3'(lc); len_code = 2'(bc);
    we_n = we; lb_n = lb; ub_n = ub;
  endtask

  // Called just after a negedge where present() set up the capture.
  task automatic run(input logic [22:0] a, input int lc, input int bc,
                     input logic we, input logic lb, input logic ub,
                     input int ncont, input bit chain, input logic [22:0] na,
                     input int nlc, input int nbc, input logic nwe,
                     input logic nlb, input logic nub);
    int L;
    int n;
    logic [22:0] m;
    L = lat_of(lc);
    n = (bc == 0) ? 8 : (bc == 1) ? 16 : ncont;
    m = (bc == 0) ? 23'h7 : (bc == 1) ? 23'hF : 23'h7FFFFF;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.a  = (a & ~m) | ((a + 23'(i)) & m);
      e.wr = !we;
      e.ln = {!ub, !lb};
      exp_q.push_back(e);
    end
    @(posedge clk);
    for (int c = 0; c < L; c++) begin
      @(negedge clk);
      if (c == 0) adv_n = 1'b1;
      chk(wait_o == 1'b1, "R4", "wait during latency", int'(wait_o), 1);
      chk(beat_valid == 1'b0, "R3", "no beat before latency", int'(beat_valid), 0);
      if (c == 0) chk(wait_oe == 1'b1, "R5", "wait drive enable", int'(wait_oe), 1);
      @(posedge clk);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) chk(beat_valid == 1'b1, "R3", "first beat at latency", int'(beat_valid), 1);
      chk(wait_o == 1'b0, "R4", "wait low in beat", int'(wait_o), 0);
      if (i == n - 1 && chain) present(na, nlc, nbc, nwe, nlb, nub);
      if (i == n - 1 && bc >= 2) ce_n = 1'b1;
      if (!(i == n - 1 && chain)) @(posedge clk);
    end
    if (!chain) begin
      @(negedge clk);
      chk(beat_valid == 1'b0, (bc >= 2) ? "R9" : "R6/R7", "burst ended",
          int'(beat_valid), 0);
      chk(wait_o == 1'b0, "R9", "wait low after end", int'(wait_o), 0);
      chk(exp_q.size() == 0, "R6/R7/R8", "beats left over", exp_q.size(), 0);
      if (bc >= 2) chk(wait_oe == 1'b0, "R5", "wait floated", int'(wait_oe), 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(beat_valid == 1'b0, "R12", "stays idle", int'(beat_valid), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(beat_valid == 1'b0 && wait_o == 1'b0 && wait_oe == 1'b0 && lane_en == 2'b00,
        "R1", "reset outputs", {beat_valid, wait_o, wait_oe, lane_en}, 0);

    // R12: strobe while deselected is ignored
    adv_n = 1'b0; addr_in = 23'h1234;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(beat_valid == 1'b0 && wait_o == 1'b0, "R12", "deselected strobe ignored",
          {beat_valid, wait_o}, 0);
    end
    adv_n = 1'b1;

    // R6 + R3 (latency 5), both lanes, read
    present(23'h12345, 0, 0, 1'b1, 1'b0, 1'b0);
    run(23'h12345, 0, 0, 1'b1, 1'b0, 1'b0, 0, 0, '0, 0, 0, 1'b1, 1'b0, 1'b0);

    // R7 + R3 (latency 10) + R11 write + R10 high lane only
    @(negedge clk);
    present(23'h00ABC, 5, 1, 1'b0, 1'b1, 1'b0);
    run(23'h00ABC, 5, 1, 1'b0, 1'b1, 1'b0, 0, 0, '0, 0, 0, 1'b1, 1'b0, 1'b0);

    // R3: code 7 clamps to 10; R12: restart on the last beat's cycle
    @(negedge clk);
    present(23'h40007, 7, 0, 1'b1, 1'b0, 1'b1);
    run(23'h40007, 7, 0, 1'b1, 1'b0, 1'b1, 0, 1, 23'h2001E, 1, 1, 1'b0, 1'b0, 1'b0);
    run(23'h2001E, 1, 1, 1'b0, 1'b0, 1'b0, 0, 0, '0, 0, 0, 1'b1, 1'b0, 1'b0);

    // R8 + R9: continuous wrap across the top, ended by chip select
    @(negedge clk);
    present(23'h7FFFFD, 2, 3, 1'b1, 1'b0, 1'b0);
    run(23'h7FFFFD, 2, 3, 1'b1, 1'b0, 1'b0, 6, 0, '0, 0, 0, 1'b1, 1'b0, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule